// File: doc/BRIEF.md
# Hardware-Triggered DMA Channel Controller

This block controls one DMA channel whose transfers are started by hardware. It watches one of eight request lines and keeps two flags: one that says requests are enabled and one that says the channel is active. It also keeps a transfer counter. An accepted request loads a programmed reload count into the counter. The block then hands transfers one at a time to a data mover outside the block, which handles addresses and bus traffic. The mover reports each finished transfer with a done pulse, and the counter drops by one for each.

Two configuration bits give four behaviours. The first bit chooses what one request starts: a whole transaction run back to back, or a single transfer. The second bit chooses whether the request enable is cleared by hardware at the end of a transaction (auto-disable) or stays set (continuous). Software writes the configuration and sets the enable through a small write port.

Top module: `dmaHwChanCtrl`

## Requirements
- R1: The request select field, `regWdata[4:2]` of a write to address 0, picks which `hwReq` line is watched. Edges on the other lines have no effect.
- R2: A write to address 1 with `regWdata[0]`=1 sets `reqEnable`. A write to address 1 with bit 0 at 0 leaves it unchanged.
- R3: A rising edge on the selected line, while `reqEnable`=1 and the channel is idle, starts the channel. On the next cycle `chanActive`=1, `xferStart`=1 and `xferCount` holds the reload value from `regWdata[12:5]`.
- R4: Each `xferDone` that answers an outstanding strobe lowers `xferCount` by one.
- R5: With whole-transaction mode on (`regWdata[0]`=1 at address 0), the next strobe comes in the cycle after each done. `chanActive` clears when the counter reaches 0.
- R6: With whole-transaction mode off, `chanActive` clears after every transfer. The next request goes on from the remaining count. The reload value is loaded only when the count is 0.
- R7: With the continuous bit clear (`regWdata[1]`=0 at address 0), `reqEnable` clears when the count reaches 0. With the bit set, `reqEnable` stays at 1.
- R8: A request that arrives while requests are disabled, or while the channel is active, is dropped and not queued. A request held high starts the channel only once.
- R9: Only one strobe is outstanding at a time. An `xferDone` that arrives with no strobe outstanding is ignored.
- R10: A reload value of 0 runs exactly one transfer.
- R11: An active-low synchronous reset clears the counter and both flags, and holds `xferStart` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = configuration, 1 = enable-set |
| regWdata | input | 13 | Write data (CNT_W+SEL_W+2 bits) |
| hwReq | input | 8 | Hardware request lines |
| xferDone | input | 1 | Data mover finished the outstanding transfer |
| xferStart | output | 1 | One-cycle strobe that starts one transfer |
| chanActive | output | 1 | Channel busy with a transaction or transfer |
| reqEnable | output | 1 | Hardware requests accepted |
| xferCount | output | 8 | Transfers remaining |

## Verification
A wrong counter shows up one cycle after the load or the done that corrupted it. It appears as a wrong `xferCount`, and later as a wrong number of strobes before `chanActive` falls. A wrong flag shows up at the next request edge. A start that should not happen shows as `chanActive` and `xferStart` rising one cycle after the edge. A start that should happen but does not leaves both outputs low. A broken outstanding-strobe rule shows as a second `xferStart` before `xferDone`, or as a count change after a stray done.

// File: rtl/dmaChanPkg.sv
package dmaChanPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic clrEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/dmaChanDp.sv
module dmaChanDp
  import dmaChanPkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               regWe,
  input  logic                               regAddr,
  input  logic [CNT_W+$clog2(NUM_REQ)+1:0]   regWdata,
  input  logic [NUM_REQ-1:0]                 hwReq,
  input  ctrlStrobe_t                        strobes,
  output logic                               reqFire,
  output logic                               reqEn,
  output logic                               wholeTxn,
  output logic                               keepEn,
  output logic                               cntIsLast,
  output logic                               cntZero,
  output logic [CNT_W-1:0]                   count
);
  localparam int SEL_W   = $clog2(NUM_REQ);
  localparam int SEL_LSB = 2;
  localparam int RLD_LSB = SEL_LSB + SEL_W;

  logic [SEL_W-1:0] cfgSel;
  logic [CNT_W-1:0] cfgReload;
  logic             selLine;
  logic             selPrev;
  logic             cfgHit;
  logic             enSetHit;

  assign cfgHit   = regWe && !regAddr;
  assign enSetHit = regWe && regAddr && regWdata[0];

  // configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wholeTxn  <= 1'b0;
      keepEn    <= 1'b0;
      cfgSel    <= '0;
      cfgReload <= '0;
    end else if (cfgHit) begin
      wholeTxn  <= regWdata[0];
      keepEn    <= regWdata[1];
      cfgSel    <= regWdata[SEL_LSB +: SEL_W];
      cfgReload <= regWdata[RLD_LSB +: CNT_W];
    end
  end

  // request line mux and rising-edge detect
  always_comb begin
    selLine = 1'b0;
    for (int i = 0; i < NUM_REQ; i++)
      if (cfgSel == SEL_W'(i)) selLine = hwReq[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) selPrev <= 1'b0;
    else       selPrev <= selLine;
  end

  assign reqFire = selLine && !selPrev && reqEn;

  // request enable: a software set wins over the hardware clear
  always_ff @(posedge clk) begin
    if (!rstN)              reqEn <= 1'b0;
    else if (enSetHit)      reqEn <= 1'b1;
    else if (strobes.clrEn) reqEn <= 1'b0;
  end

  // transfer counter
  always_ff @(posedge clk) begin
    if (!rstN)
      count <= '0;
    else if (strobes.loadCnt)
      count <= (cfgReload == '0) ? CNT_W'(1) : cfgReload;
    else if (strobes.decCnt)
      count <= count - 1'b1;
  end

  assign cntZero   = (count == '0);
  assign cntIsLast = (count == CNT_W'(1));

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decCnt && !cntZero) |=> (count == $past(count) - 1'b1)); // R4
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCnt |=> !cntZero); // R10
  AST_LOAD_DEC_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadCnt && strobes.decCnt)); // R9
endmodule

// File: rtl/dmaChanCtrl.sv
module dmaChanCtrl
  import dmaChanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqFire,
  input  logic        reqEn,
  input  logic        wholeTxn,
  input  logic        keepEn,
  input  logic        cntIsLast,
  input  logic        cntZero,
  input  logic        xferDone,
  output ctrlStrobe_t strobes,
  output logic        chanActive,
  output logic        xferStart
);
  logic busy;
  logic startTxn;
  logic doneAcc;
  logic lastDone;

  assign startTxn  = reqFire && !chanActive;
  assign doneAcc   = xferDone && busy;
  assign lastDone  = doneAcc && cntIsLast;
  assign xferStart = chanActive && !busy;

  always_comb begin
    strobes         = '0;
    strobes.loadCnt = startTxn && cntZero;
    strobes.decCnt  = doneAcc;
    strobes.clrEn   = lastDone && !keepEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      chanActive <= 1'b0;
    else if (startTxn)
      chanActive <= 1'b1;
    else if (doneAcc && (lastDone || !wholeTxn))
      chanActive <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busy <= 1'b0;
    else if (xferStart) busy <= 1'b1;
    else if (doneAcc)   busy <= 1'b0;
  end

  AST_START_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    startTxn |=> (chanActive && xferStart)); // R3
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    lastDone |=> !chanActive); // R5
  AST_PER_XFER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneAcc && !wholeTxn) |=> !chanActive); // R6
  AST_KEEP_EN: assert property (@(posedge clk) disable iff (!rstN)
    (doneAcc && keepEn && reqEn) |=> reqEn); // R7
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!chanActive && !reqEn) |=> !chanActive); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart); // R9
  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive |-> !busy); // R11
endmodule

// File: rtl/dmaHwChanCtrl.sv
module dmaHwChanCtrl
  import dmaChanPkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWe,
  input  logic                             regAddr,
  input  logic [CNT_W+$clog2(NUM_REQ)+1:0] regWdata,
  input  logic [NUM_REQ-1:0]               hwReq,
  input  logic                             xferDone,
  output logic                             xferStart,
  output logic                             chanActive,
  output logic                             reqEnable,
  output logic [CNT_W-1:0]                 xferCount
);
  ctrlStrobe_t strobes;
  logic reqFire;
  logic wholeTxn;
  logic keepEn;
  logic cntIsLast;
  logic cntZero;

  dmaChanDp #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .hwReq(hwReq), .strobes(strobes),
    .reqFire(reqFire), .reqEn(reqEnable), .wholeTxn(wholeTxn),
    .keepEn(keepEn), .cntIsLast(cntIsLast), .cntZero(cntZero),
    .count(xferCount)
  );

  dmaChanCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqFire(reqFire), .reqEn(reqEnable),
    .wholeTxn(wholeTxn), .keepEn(keepEn), .cntIsLast(cntIsLast),
    .cntZero(cntZero), .xferDone(xferDone), .strobes(strobes),
    .chanActive(chanActive), .xferStart(xferStart)
  );
endmodule

// File: tb/sim_dmaHwChanCtrl.sv
module sim_dmaHwChanCtrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] sel;
    logic       whole;
    logic       keep;
    logic [7:0] reload;
    logic [7:0] expN;
    logic       expEn;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b1, 1'b0, 8'd3, 8'd3, 1'b0},
    '{3'd7, 1'b1, 1'b1, 8'd2, 8'd2, 1'b1},
    '{3'd3, 1'b0, 1'b0, 8'd3, 8'd3, 1'b0},
    '{3'd5, 1'b0, 1'b1, 8'd2, 8'd2, 1'b1},
    '{3'd1, 1'b1, 1'b0, 8'd0, 8'd1, 1'b0},
    '{3'd6, 1'b0, 1'b1, 8'd0, 8'd1, 1'b1},
    '{3'd4, 1'b1, 1'b1, 8'd5, 8'd5, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic        regAddr;
  logic [12:0] regWdata;
  logic [7:0]  hwReq;
  logic        xferDone;
  logic        xferStart;
  logic        chanActive;
  logic        reqEnable;
  logic [7:0]  xferCount;

  int vectors = 0;
  int miscompares = 0;
  int seenStrobes;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaHwChanCtrl u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .hwReq(hwReq), .xferDone(xferDone),
    .xferStart(xferStart), .chanActive(chanActive),
    .reqEnable(reqEnable), .xferCount(xferCount)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [12:0] data);
    regWe = 1'b1; regAddr = addr; regWdata = data;
    tick();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic writeCfg(input logic [2:0] sel, input logic whole,
                          input logic keep, input logic [7:0] reload);
    writeReg(1'b0, {reload, sel, keep, whole});
  endtask

  task automatic pulseReq(input int line);
    hwReq[line] = 1'b1;
    tick();
    hwReq[line] = 1'b0;
  endtask

  task automatic serveUntilIdle();
    for (int i = 0; i < 300; i++) begin
      if (xferStart) begin
        seenStrobes++;
        tick(); tick();
        xferDone = 1'b1;
        tick();
        xferDone = 1'b0;
      end else if (!chanActive) begin
        break;
      end else begin
        tick();
      end
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = 1'b0; regWdata = '0;
    hwReq = '0; xferDone = 1'b0;
    repeat (3) tick();
    // R11 reset state
    chk("R11 count", int'(xferCount), 0);
    chk("R11 active", int'(chanActive), 0);
    chk("R11 enable", int'(reqEnable), 0);
    chk("R11 strobe", int'(xferStart), 0);
    rstN = 1'b1;
    tick();

    // table of mode/reload vectors
    for (int v = 0; v < NVEC; v++) begin
      int nReq;
      writeCfg(VECS[v].sel, VECS[v].whole, VECS[v].keep, VECS[v].reload);
      writeReg(1'b1, 13'd1);
      nReq = VECS[v].whole ? 1 : int'(VECS[v].expN);
      seenStrobes = 0;
      for (int k = 0; k < nReq; k++) begin
        pulseReq(int'(VECS[v].sel));
        serveUntilIdle();
      end
      chk("R5 R6 R10 strobe total", seenStrobes, int'(VECS[v].expN));
      chk("R7 enable after txn", int'(reqEnable), int'(VECS[v].expEn));
      chk("R5 active after txn", int'(chanActive), 0);
      if (VECS[v].expEn) begin
        writeReg(1'b0, 13'd0);
        rstN = 1'b0; tick(); rstN = 1'b1; tick();
      end
    end

    // R8 request while disabled is dropped, not queued
    writeCfg(3'd2, 1'b1, 1'b0, 8'd2);
    pulseReq(2);
    chk("R8 disabled request", int'(chanActive), 0);
    writeReg(1'b1, 13'd0);
    chk("R2 write 0 no effect", int'(reqEnable), 0);
    writeReg(1'b1, 13'd1);
    chk("R8 not queued", int'(chanActive), 0);
    chk("R2 enable set", int'(reqEnable), 1);

    // R1 unselected line ignored
    pulseReq(5);
    chk("R1 other line", int'(chanActive), 0);

    // R3 start timing and load
    pulseReq(2);
    chk("R3 active", int'(chanActive), 1);
    chk("R3 strobe", int'(xferStart), 1);
    chk("R3 count loaded", int'(xferCount), 2);
    tick();
    // R9 no second strobe before done; R8 request while active dropped
    pulseReq(2);
    tick();
    chk("R9 one outstanding", int'(xferStart), 0);
    chk("R9 count held", int'(xferCount), 2);
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
    chk("R4 decrement", int'(xferCount), 1);
    chk("R5 back to back", int'(xferStart), 1);
    seenStrobes = 0;
    serveUntilIdle();
    chk("R8 active request dropped", seenStrobes, 1);
    chk("R7 auto-disable", int'(reqEnable), 0);
    chk("R5 count zero", int'(xferCount), 0);

    // R9 stray done ignored
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
    tick();
    chk("R9 stray done count", int'(xferCount), 0);
    chk("R9 stray done strobe", int'(xferStart), 0);

    // R8 held-high request starts once
    writeCfg(3'd4, 1'b1, 1'b1, 8'd1);
    writeReg(1'b1, 13'd1);
    hwReq[4] = 1'b1;
    tick();
    seenStrobes = 0;
    serveUntilIdle();
    repeat (5) tick();
    chk("R8 held high once", seenStrobes, 1);
    chk("R8 held high idle", int'(chanActive), 0);
    hwReq[4] = 1'b0;
    tick();

    // R6 per-transfer continues from remaining count
    writeCfg(3'd6, 1'b0, 1'b1, 8'd3);
    pulseReq(6);
    serveUntilIdle();
    chk("R6 idle after one", int'(chanActive), 0);
    chk("R6 count after one", int'(xferCount), 2);
    writeCfg(3'd6, 1'b0, 1'b1, 8'd7);
    pulseReq(6);
    serveUntilIdle();
    chk("R6 no reload midway", int'(xferCount), 1);
    pulseReq(6);
    serveUntilIdle();
    chk("R6 count end", int'(xferCount), 0);
    chk("R7 continuous keeps enable", int'(reqEnable), 1);

    finishRun();
  end
endmodule